// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Lane Unit

This block sits between a processor core and a word-wide data memory in a byte-addressed system. On the store side it forms the effective address from a base register and a signed displacement. From that address it produces the word address for memory, a per-lane write-enable mask and the store data moved into the correct byte lanes. Lanes are ordered big-endian: the byte at the lowest address of a word sits in the most significant lane. Accesses whose address does not suit their size are flagged, and they write nothing.

On the load side the block takes the word returned by memory, the low address bits, the access size and a signed/unsigned selector. It picks the addressed byte or halfword and widens it to a full word, either by sign extension or by zero extension. Both paths are registered, so every output appears one clock after the inputs that produce it.

Top module: `lane_unit`

## Requirements
- R1: The effective address is `base_i` plus `disp_i` sign-extended from 16 bits. `mem_addr_o` equals that address with bits 1:0 cleared, one cycle after the request.
- R2: A byte store (`size_i` = 2'b00) enables exactly one lane: offset 0 gives `wr_be_o` = 4'b1000, offset 1 gives 4'b0100, offset 2 gives 4'b0010 and offset 3 gives 4'b0001. `wr_data_o` carries the store byte copied into all four lanes.
- R3: An aligned halfword store (`size_i` = 2'b01) gives `wr_be_o` = 4'b1100 at offset 0 and 4'b0011 at offset 2. `wr_data_o` carries the low 16 bits of the store data copied into both halves.
- R4: An aligned word store (`size_i` = 2'b10 or 2'b11) gives `wr_be_o` = 4'b1111, with `wr_data_o` equal to the store data unchanged.
- R5: A halfword request with address bit 0 set, or a word request with either of address bits 1:0 set, raises `misalign_o` one cycle later and forces `wr_be_o` to zero. Byte requests are never misaligned.
- R6: `wr_be_o` is zero whenever the previous cycle did not hold a store request (`req_i` and `we_i` both high). `misalign_o` is zero when `req_i` was low.
- R7: A byte load returns bits 31:24 for offset 0, 23:16 for offset 1, 15:8 for offset 2 and 7:0 for offset 3. The byte is sign-extended when `ld_unsigned_i` is 0 and zero-extended when it is 1.
- R8: A halfword load returns bits 31:16 when `ld_off_i[1]` is 0 and bits 15:0 when it is 1; `ld_off_i[0]` is ignored. The halfword is extended as in R7.
- R9: A word load returns `ld_word_i` unchanged, for any offset and either setting of `ld_unsigned_i`. `ld_value_o` follows its inputs after one cycle.
- R10: While `rst` is high, all outputs are zero after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request valid |
| we_i | input | 1 | Request is a store |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement |
| size_i | input | 2 | Access size: 00 byte, 01 half, 1x word |
| st_data_i | input | 32 | Register data to store |
| ld_word_i | input | 32 | Word read from memory |
| ld_off_i | input | 2 | Low address bits of the load |
| ld_size_i | input | 2 | Load size, same encoding as size_i |
| ld_unsigned_i | input | 1 | 1 selects zero extension |
| mem_addr_o | output | 32 | Word-aligned memory address |
| wr_be_o | output | 4 | Per-lane write enables, bit 3 = lowest address |
| wr_data_o | output | 32 | Lane-positioned write data |
| misalign_o | output | 1 | Misaligned access flag |
| ld_value_o | output | 32 | Extended load result |

## Verification
Byte stores are tried at all four offsets. Each offset has its own mask, so a lane numbered in little-endian order would show up at once. Halfword and word stores are tried both aligned and at every misaligned offset, which separates the two alignment rules from each other and from byte accesses. Displacements are tried negative and positive so that a missing sign extension shows in the word address. Loads use words whose bytes have their top bits set in some lanes and clear in others. That way the sign-extended and zero-extended results differ, and picking the wrong lane or the wrong half gives a different value.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lane_ea_gen.sv
module lane_ea_gen #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = ADDR_W - DISP_W;

  always_comb begin
    ea = base + {{EXT_W{disp[DISP_W-1]}}, disp};
  end
endmodule

// File: rtl/lane_store_pack.sv
module lane_store_pack
  import lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  acc_size_e                   size,
  input  logic [DATA_W-1:0]           data,
  output logic [DATA_W/8-1:0]         mask,
  output logic [DATA_W-1:0]           wdata,
  output logic                        misal
);
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);
  localparam int NH    = NB / 2;

  always_comb begin
    mask  = '0;
    wdata = data;
    misal = 1'b0;
    unique case (size)
      SZ_BYTE: begin
        wdata = {NB{data[7:0]}};
        for (int j = 0; j < NB; j++) begin
          mask[j] = (OFF_W'(NB - 1 - j) == off);
        end
      end
      SZ_HALF: begin
        wdata = {NH{data[15:0]}};
        misal = off[0];
        for (int j = 0; j < NB; j++) begin
          mask[j] = (OFF_W'((NB - 1 - j) / 2) == (off >> 1));
        end
      end
      default: begin
        wdata = data;
        misal = |off;
        mask  = '1;
      end
    endcase
  end
endmodule

// File: rtl/lane_load_unpack.sv
module lane_load_unpack
  import lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]           word,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  acc_size_e                   size,
  input  logic                        zext,
  output logic [DATA_W-1:0]           value
);
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);
  localparam int NH    = NB / 2;

  logic [7:0]  bsel;
  logic [15:0] hsel;

  always_comb begin
    bsel = '0;
    for (int j = 0; j < NB; j++) begin
      if (OFF_W'(NB - 1 - j) == off) bsel = word[8*j +: 8];
    end
    hsel = '0;
    for (int k = 0; k < NH; k++) begin
      if (OFF_W'(NH - 1 - k) == (off >> 1)) hsel = word[16*k +: 16];
    end
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: value = {{(DATA_W-8){~zext & bsel[7]}}, bsel};
      SZ_HALF: value = {{(DATA_W-16){~zext & hsel[15]}}, hsel};
      default: value = word;
    endcase
  end
endmodule

// File: rtl/lane_unit.sv
module lane_unit
  import lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DISP_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [DISP_W-1:0]   disp_i,
  input  logic [1:0]          size_i,
  input  logic [DATA_W-1:0]   st_data_i,
  input  logic [DATA_W-1:0]   ld_word_i,
  input  logic [$clog2(DATA_W/8)-1:0] ld_off_i,
  input  logic [1:0]          ld_size_i,
  input  logic                ld_unsigned_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W/8-1:0] wr_be_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic                misalign_o,
  output logic [DATA_W-1:0]   ld_value_o
);
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);

  logic [ADDR_W-1:0] ea;
  logic [NB-1:0]     mask;
  logic [DATA_W-1:0] wdata;
  logic              misal;
  logic [DATA_W-1:0] ld_val;

  lane_ea_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_ea (
    .base (base_i),
    .disp (disp_i),
    .ea   (ea)
  );

  lane_store_pack #(.DATA_W(DATA_W)) u_st (
    .off   (ea[OFF_W-1:0]),
    .size  (acc_size_e'(size_i)),
    .data  (st_data_i),
    .mask  (mask),
    .wdata (wdata),
    .misal (misal)
  );

  lane_load_unpack #(.DATA_W(DATA_W)) u_ld (
    .word  (ld_word_i),
    .off   (ld_off_i),
    .size  (acc_size_e'(ld_size_i)),
    .zext  (ld_unsigned_i),
    .value (ld_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr_o <= '0;
      wr_be_o    <= '0;
      wr_data_o  <= '0;
      misalign_o <= 1'b0;
      ld_value_o <= '0;
    end else begin
      mem_addr_o <= {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      wr_be_o    <= (req_i && we_i && !misal) ? mask : '0;
      wr_data_o  <= wdata;
      misalign_o <= req_i && misal;
      ld_value_o <= ld_val;
    end
  end
endmodule

// File: rtl/lane_unit_chk.sv
module lane_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                req_i,
  input logic                we_i,
  input logic [1:0]          size_i,
  input logic [1:0]          ld_size_i,
  input logic                ld_unsigned_i,
  input logic [DATA_W/8-1:0] wr_be_o,
  input logic                misalign_o,
  input logic [DATA_W-1:0]   ld_value_o
);
  // R5
  misal_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    misalign_o |-> (wr_be_o == '0));

  // R6
  no_store_no_be_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(req_i && we_i) |-> (wr_be_o == '0));

  // R6
  misal_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    misalign_o |-> $past(req_i));

  // R2
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (rst)
    $past(req_i && we_i && size_i == 2'b00) |-> ($countones(wr_be_o) == 1));

  // R3
  half_two_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(req_i && we_i && size_i == 2'b01) && !misalign_o) |-> ($countones(wr_be_o) == 2));

  // R7
  byte_zext_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ld_unsigned_i && ld_size_i == 2'b00) |-> (ld_value_o[DATA_W-1:8] == '0));

  // R8
  half_zext_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ld_unsigned_i && ld_size_i == 2'b01) |-> (ld_value_o[DATA_W-1:16] == '0));
endmodule

bind lane_unit lane_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_i         (req_i),
  .we_i          (we_i),
  .size_i        (size_i),
  .ld_size_i     (ld_size_i),
  .ld_unsigned_i (ld_unsigned_i),
  .wr_be_o       (wr_be_o),
  .misalign_o    (misalign_o),
  .ld_value_o    (ld_value_o)
);

// File: tb/tb_lane_unit.sv
`timescale 1ns/1ps
module tb_lane_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_i, we_i;
  logic [31:0] base_i;
  logic [15:0] disp_i;
  logic [1:0]  size_i;
  logic [31:0] st_data_i;
  logic [31:0] ld_word_i;
  logic [1:0]  ld_off_i;
  logic [1:0]  ld_size_i;
  logic        ld_unsigned_i;
  logic [31:0] mem_addr_o;
  logic [3:0]  wr_be_o;
  logic [31:0] wr_data_o;
  logic        misalign_o;
  logic [31:0] ld_value_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lane_unit dut (
    .clk(clk), .rst(rst), .req_i(req_i), .we_i(we_i), .base_i(base_i),
    .disp_i(disp_i), .size_i(size_i), .st_data_i(st_data_i),
    .ld_word_i(ld_word_i), .ld_off_i(ld_off_i), .ld_size_i(ld_size_i),
    .ld_unsigned_i(ld_unsigned_i), .mem_addr_o(mem_addr_o), .wr_be_o(wr_be_o),
    .wr_data_o(wr_data_o), .misalign_o(misalign_o), .ld_value_o(ld_value_o)
  );

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_store(string tag, logic req, logic we, logic [31:0] base,
                          logic [15:0] disp, logic [1:0] sz, logic [31:0] data,
                          logic [31:0] e_addr, logic [3:0] e_be,
                          logic [31:0] e_data, logic e_mis);
    @(negedge clk);
    req_i = req; we_i = we; base_i = base; disp_i = disp;
    size_i = sz; st_data_i = data;
    @(posedge clk); #1;
    check32({tag, " addr"}, mem_addr_o, e_addr);
    check32({tag, " be"}, {28'd0, wr_be_o}, {28'd0, e_be});
    if (e_be != 4'b0000) check32({tag, " data"}, wr_data_o, e_data);
    check32({tag, " misalign"}, {31'd0, misalign_o}, {31'd0, e_mis});
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic do_load(string tag, logic [31:0] word, logic [1:0] off,
                         logic [1:0] sz, logic uns, logic [31:0] e_val);
    @(negedge clk);
    ld_word_i = word; ld_off_i = off; ld_size_i = sz; ld_unsigned_i = uns;
    @(posedge clk); #1;
    check32(tag, ld_value_o, e_val);
  endtask

  task automatic test_reset();
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; base_i = 32'h1234_5678; disp_i = 16'h0;
    size_i = 2'b10; st_data_i = 32'hFFFF_FFFF; ld_word_i = 32'hFFFF_FFFF;
    ld_off_i = 2'b00; ld_size_i = 2'b10; ld_unsigned_i = 1'b0;
    rst = 1'b1;
    @(posedge clk); #1;
    check32("R10 addr", mem_addr_o, 32'h0);
    check32("R10 be", {28'd0, wr_be_o}, 32'h0);
    check32("R10 data", wr_data_o, 32'h0);
    check32("R10 misalign", {31'd0, misalign_o}, 32'h0);
    check32("R10 load", ld_value_o, 32'h0);
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; ld_word_i = 32'h0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic test_address();
    do_store("R1 neg disp", 1, 1, 32'h0000_1000, 16'hFFFC, 2'b10, 32'h0,
             32'h0000_0FFC, 4'b1111, 32'h0, 1'b0);
    do_store("R1 pos disp", 1, 1, 32'h0000_0010, 16'h7FFF, 2'b00, 32'h0000_005A,
             32'h0000_800C, 4'b0001, 32'h5A5A_5A5A, 1'b0);
  endtask

  task automatic test_byte_store();
    do_store("R2 off0", 1, 1, 32'h0000_2000, 16'h0000, 2'b00, 32'h1122_33AB,
             32'h0000_2000, 4'b1000, 32'hABAB_ABAB, 1'b0);
    do_store("R2 off1", 1, 1, 32'h0000_2000, 16'h0001, 2'b00, 32'h0000_00C7,
             32'h0000_2000, 4'b0100, 32'hC7C7_C7C7, 1'b0);
    do_store("R2 off2", 1, 1, 32'h0000_2001, 16'h0001, 2'b00, 32'h0000_0011,
             32'h0000_2000, 4'b0010, 32'h1111_1111, 1'b0);
    do_store("R2 off3", 1, 1, 32'h0000_2003, 16'h0000, 2'b00, 32'hFFFF_FF3E,
             32'h0000_2000, 4'b0001, 32'h3E3E_3E3E, 1'b0);
  endtask

  task automatic test_half_store();
    do_store("R3 off0", 1, 1, 32'h0000_3000, 16'h0000, 2'b01, 32'hAAAA_1234,
             32'h0000_3000, 4'b1100, 32'h1234_1234, 1'b0);
    do_store("R3 off2", 1, 1, 32'h0000_3000, 16'h0002, 2'b01, 32'h0000_BEEF,
             32'h0000_3000, 4'b0011, 32'hBEEF_BEEF, 1'b0);
  endtask

  task automatic test_word_store();
    do_store("R4 word", 1, 1, 32'h0000_4000, 16'h0004, 2'b10, 32'hDEAD_BEEF,
             32'h0000_4004, 4'b1111, 32'hDEAD_BEEF, 1'b0);
    do_store("R4 word alt", 1, 1, 32'h0000_4000, 16'h0008, 2'b11, 32'h0123_4567,
             32'h0000_4008, 4'b1111, 32'h0123_4567, 1'b0);
  endtask

  task automatic test_misalign();
    do_store("R5 half off1", 1, 1, 32'h0000_5000, 16'h0001, 2'b01, 32'h0,
             32'h0000_5000, 4'b0000, 32'h0, 1'b1);
    do_store("R5 half off3", 1, 1, 32'h0000_5000, 16'h0003, 2'b01, 32'h0,
             32'h0000_5000, 4'b0000, 32'h0, 1'b1);
    do_store("R5 word off2", 1, 1, 32'h0000_5000, 16'h0002, 2'b10, 32'h0,
             32'h0000_5000, 4'b0000, 32'h0, 1'b1);
    do_store("R5 word off1", 1, 1, 32'h0000_5000, 16'h0001, 2'b10, 32'h0,
             32'h0000_5000, 4'b0000, 32'h0, 1'b1);
    do_store("R5 load misal", 1, 0, 32'h0000_5002, 16'h0001, 2'b10, 32'h0,
             32'h0000_5000, 4'b0000, 32'h0, 1'b1);
  endtask

  task automatic test_no_store();
    do_store("R6 load req", 1, 0, 32'h0000_6000, 16'h0000, 2'b10, 32'hFFFF_FFFF,
             32'h0000_6000, 4'b0000, 32'h0, 1'b0);
    do_store("R6 no req", 0, 1, 32'h0000_6001, 16'h0000, 2'b01, 32'hFFFF_FFFF,
             32'h0000_6000, 4'b0000, 32'h0, 1'b0);
  endtask

  task automatic test_byte_load();
    do_load("R7 off0 s", 32'h807F_01FF, 2'd0, 2'b00, 1'b0, 32'hFFFF_FF80);
    do_load("R7 off0 u", 32'h807F_01FF, 2'd0, 2'b00, 1'b1, 32'h0000_0080);
    do_load("R7 off1 s", 32'h807F_01FF, 2'd1, 2'b00, 1'b0, 32'h0000_007F);
    do_load("R7 off2 s", 32'h807F_01FF, 2'd2, 2'b00, 1'b0, 32'h0000_0001);
    do_load("R7 off3 s", 32'h807F_01FF, 2'd3, 2'b00, 1'b0, 32'hFFFF_FFFF);
    do_load("R7 off3 u", 32'h807F_01FF, 2'd3, 2'b00, 1'b1, 32'h0000_00FF);
  endtask

  task automatic test_half_load();
    do_load("R8 off0 s", 32'h8001_7FFE, 2'd0, 2'b01, 1'b0, 32'hFFFF_8001);
    do_load("R8 off0 u", 32'h8001_7FFE, 2'd0, 2'b01, 1'b1, 32'h0000_8001);
    do_load("R8 off2 s", 32'h8001_7FFE, 2'd2, 2'b01, 1'b0, 32'h0000_7FFE);
    do_load("R8 off2 s neg", 32'h1234_C000, 2'd2, 2'b01, 1'b0, 32'hFFFF_C000);
    do_load("R8 off3 bit0 ignored", 32'h8001_7FFE, 2'd3, 2'b01, 1'b0, 32'h0000_7FFE);
  endtask

  task automatic test_word_load();
    do_load("R9 word off0", 32'h8765_4321, 2'd0, 2'b10, 1'b0, 32'h8765_4321);
    do_load("R9 word off2 u", 32'hF00D_CAFE, 2'd2, 2'b10, 1'b1, 32'hF00D_CAFE);
    do_load("R9 word alt", 32'h0BAD_F00D, 2'd1, 2'b11, 1'b0, 32'h0BAD_F00D);
  endtask

  initial begin
    rst = 1'b1;
    req_i = 1'b0; we_i = 1'b0; base_i = '0; disp_i = '0; size_i = '0;
    st_data_i = '0; ld_word_i = '0; ld_off_i = '0; ld_size_i = '0;
    ld_unsigned_i = 1'b0;
    repeat (3) @(posedge clk);
    test_reset();
    test_address();
    test_byte_store();
    test_half_store();
    test_word_store();
    test_misalign();
    test_no_store();
    test_byte_load();
    test_half_load();
    test_word_load();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule